// File: doc/BRIEF.md
# Register-List Block Transfer Sequencer

This block turns one multiple-register transfer command into a series of single 32-bit memory accesses. A command names an operation (stack push, stack pop, multiple store, multiple load), an 8-bit list of general registers, an extra flag, a base register index, the starting base or stack-pointer value and the current PC. The sequencer works through the list in the order the operation calls for. It issues one access per cycle on a request/ready bus, reads the register file for stores and writes it for loads.

When the last access completes, the sequencer pulses `done` for one cycle. With that pulse it presents the updated base or stack-pointer value, a writeback enable, and a pipeline-flush request if a value was loaded into the PC. Instruction decode and the memory itself sit outside the block. Commands offered while the block is busy are ignored.

Top module: `reglist_xfer_seq`

## Requirements
- R1: Push (cmdOp=0) stores the link register (index 14) first when cmdExtra is 1, then the listed registers from 7 down to 0. The stack pointer drops by 4 before each store, and each store goes to that value with bits 1:0 cleared.
- R2: Pop (cmdOp=1) loads the listed registers from 0 up to 7, then the PC (index 15) when cmdExtra is 1. Each load reads the pointer with bits 1:0 cleared, and the pointer then becomes that address plus 4. Register writes (rfWrEn) happen only in the cycle an access completes.
- R3: A word loaded into the PC (index 15) is written with bit 0 cleared, and `flush` is high in the `done` cycle of that command. No other command raises `flush`.
- R4: Multiple store (cmdOp=2) and multiple load (cmdOp=3) start at cmdBase with bits 1:0 cleared. They move the listed registers in ascending order, and the address rises by 4 per register.
- R5: In the `done` cycle, `wbData` holds the final pointer. For push it is cmdBase−4·n and for pop the last load address plus 4. For a multiple transfer it is the aligned base plus 4·n, or cmdBase unchanged for an empty push or pop with cmdExtra 0.
- R6: `wbEn` is high only in the `done` cycle. It is low when a multiple load lists its own base register (cmdBaseIdx) and high in every other case.
- R7: With an empty list, a multiple load reads one word at the aligned base into the PC and requests a flush. A multiple store writes cmdPc+2 there. Both then set the base to aligned base + 0x40.
- R8: `done` pulses for one cycle, exactly one cycle after the last access completes. `busy` falls in the next cycle, and cmdValid is ignored while `busy` is high.
- R9: While memReq is high and memReady is low, memAddr, memWe and memWdata hold their values and memReq stays high.
- R10: After reset the block is idle: `busy`, `memReq` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command offer, taken when not busy |
| cmdOp | input | 2 | 0 push, 1 pop, 2 multiple store, 3 multiple load |
| cmdList | input | 8 | Register list, bit i selects register i |
| cmdExtra | input | 1 | Push: also store link; pop: also load PC |
| cmdBaseIdx | input | 3 | Base register index for multiple load/store |
| cmdBase | input | 32 | Starting stack pointer or base value |
| cmdPc | input | 32 | Current PC, used by an empty-list store |
| busy | output | 1 | Command in progress |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Access is a write |
| memAddr | output | 32 | Word-aligned access address |
| memWdata | output | 32 | Store data |
| memReady | input | 1 | Access completes this cycle |
| memRdata | input | 32 | Load data, valid with memReady |
| rfRdEn | output | 1 | Register-file read strobe |
| rfRdIdx | output | 4 | Register to read (14 link) |
| rfRdData | input | 32 | Read data, combinational |
| rfWrEn | output | 1 | Register-file write strobe |
| rfWrIdx | output | 4 | Register to write (15 PC) |
| rfWrData | output | 32 | Write data |
| done | output | 1 | One-cycle completion pulse |
| wbEn | output | 1 | Write wbData back to base or stack pointer |
| wbData | output | 32 | Final base or stack-pointer value |
| flush | output | 1 | Pipeline flush request |

## Verification
The assertions check the properties that hold on every cycle. A stalled request keeps its address, direction and data. A PC write never has bit 0 set. Register writes only happen as an access completes, writeback and flush appear only with `done`, `busy` falls after `done`, and `busy` only rises after an offered command. Transfer order, addresses, final pointer values, writeback suppression, empty-list behaviour and done timing depend on the whole command. The bench shows these by comparing every access and every completion against a model of each command, under random ready stalls and with commands offered while the block is busy.

// File: rtl/rlx_pkg.sv
package rlx_pkg;
  typedef enum logic [1:0] {
    OP_PUSH = 2'd0,
    OP_POP  = 2'd1,
    OP_STM  = 2'd2,
    OP_LDM  = 2'd3
  } xferOp_t;

  localparam int IDX_W = 4;
  localparam logic [IDX_W-1:0] IDX_LINK = 4'd14;
  localparam logic [IDX_W-1:0] IDX_PC   = 4'd15;

  typedef struct packed {
    logic load;
    logic step;
  } seqStrobe_t;
endpackage

// File: rtl/rlx_pick.sv
module rlx_pick #(
  parameter int LIST_W  = 8,
  parameter int IDX_W   = 4,
  parameter bit DESCEND = 1'b0
) (
  input  logic [LIST_W-1:0] mask,
  output logic [IDX_W-1:0]  idx,
  output logic [LIST_W-1:0] oneHot
);
  generate
    if (DESCEND) begin : g_high
      always_comb begin
        idx = '0;
        for (int i = 0; i < LIST_W; i++) begin
          if (mask[i]) idx = IDX_W'(i);
        end
      end
    end else begin : g_low
      always_comb begin
        idx = '0;
        for (int i = LIST_W - 1; i >= 0; i--) begin
          if (mask[i]) idx = IDX_W'(i);
        end
      end
    end
  endgenerate

  assign oneHot = mask & (LIST_W'(1) << idx);
endmodule

// File: rtl/rlx_ctrl.sv
module rlx_ctrl
  import rlx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       memReady,
  input  logic       itemsLeft,
  input  logic       lastItem,
  output seqStrobe_t strobe,
  output logic       memReq,
  output logic       busy,
  output logic       done
);
  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_FIN} ctrlState_t;
  ctrlState_t state, stateNext;

  always_comb begin
    memReq      = (state == ST_XFER) && itemsLeft;
    strobe.load = (state == ST_IDLE) && cmdValid;
    strobe.step = memReq && memReady;
    busy        = (state != ST_IDLE);
    done        = (state == ST_FIN);
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (cmdValid) stateNext = ST_XFER;
      ST_XFER: if (!itemsLeft || (strobe.step && lastItem)) stateNext = ST_FIN;
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/rlx_datapath.sv
module rlx_datapath
  import rlx_pkg::*;
#(
  parameter int LIST_W       = 8,
  parameter int DATA_W       = 32,
  parameter int EMPTY_STRIDE = 64,
  localparam int SEL_W       = $clog2(LIST_W),
  localparam int WORD_BYTES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              memReq,
  input  logic [1:0]        cmdOp,
  input  logic [LIST_W-1:0] cmdList,
  input  logic              cmdExtra,
  input  logic [SEL_W-1:0]  cmdBaseIdx,
  input  logic [DATA_W-1:0] cmdBase,
  input  logic [DATA_W-1:0] cmdPc,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [DATA_W-1:0] rfRdData,
  output logic              itemsLeft,
  output logic              lastItem,
  output logic              memWe,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              rfRdEn,
  output logic [IDX_W-1:0]  rfRdIdx,
  output logic              rfWrEn,
  output logic [IDX_W-1:0]  rfWrIdx,
  output logic [DATA_W-1:0] rfWrData,
  output logic [DATA_W-1:0] wbData,
  output logic              wbKeep,
  output logic              flushPend
);
  localparam logic [DATA_W-1:0] ALIGN_MASK = {{(DATA_W-2){1'b1}}, 2'b00};
  localparam logic [DATA_W-1:0] STEP       = DATA_W'(WORD_BYTES);
  localparam logic [DATA_W-1:0] EMPTY_ADV  = DATA_W'(EMPTY_STRIDE);

  xferOp_t           opR;
  logic [LIST_W-1:0] maskR;
  logic              extraR;
  logic [DATA_W-1:0] ptrR;
  logic [DATA_W-1:0] pcPlus2R;
  logic              suppressR;
  logic              flushR;

  logic [IDX_W-1:0]  loIdx, hiIdx, curIdx;
  logic [LIST_W-1:0] loOh, hiOh, curOh;
  logic              isPush, isLoad, curIsExtra, stmPcItem;
  logic [DATA_W-1:0] ptrNext;

  rlx_pick #(.LIST_W(LIST_W), .IDX_W(IDX_W), .DESCEND(1'b0)) u_pickLow (
    .mask(maskR), .idx(loIdx), .oneHot(loOh)
  );
  rlx_pick #(.LIST_W(LIST_W), .IDX_W(IDX_W), .DESCEND(1'b1)) u_pickHigh (
    .mask(maskR), .idx(hiIdx), .oneHot(hiOh)
  );

  always_comb begin
    isPush     = (opR == OP_PUSH);
    isLoad     = (opR == OP_POP) || (opR == OP_LDM);
    // push handles its extra item first, the others handle it last
    curIsExtra = isPush ? extraR : (maskR == '0);
    curOh      = isPush ? hiOh : loOh;
    if (curIsExtra) curIdx = isPush ? IDX_LINK : IDX_PC;
    else            curIdx = isPush ? hiIdx : loIdx;
    stmPcItem  = (opR == OP_STM) && curIsExtra;
    itemsLeft  = (|maskR) || extraR;
    lastItem   = ($countones({maskR, extraR}) == 1);

    case (opR)
      OP_PUSH: begin
        memAddr = (ptrR - STEP) & ALIGN_MASK;
        ptrNext = ptrR - STEP;
      end
      OP_POP: begin
        memAddr = ptrR & ALIGN_MASK;
        ptrNext = (ptrR & ALIGN_MASK) + STEP;
      end
      default: begin
        memAddr = ptrR;
        ptrNext = curIsExtra ? ptrR + EMPTY_ADV : ptrR + STEP;
      end
    endcase

    memWe    = !isLoad;
    memWdata = stmPcItem ? pcPlus2R : rfRdData;
    rfRdEn   = memReq && !isLoad && !stmPcItem;
    rfRdIdx  = curIdx;
    rfWrEn   = strobe.step && isLoad;
    rfWrIdx  = curIdx;
    rfWrData = (curIdx == IDX_PC) ? {memRdata[DATA_W-1:1], 1'b0} : memRdata;
    wbData   = ptrR;
    wbKeep   = !suppressR;
    flushPend = flushR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opR       <= OP_PUSH;
      maskR     <= '0;
      extraR    <= 1'b0;
      ptrR      <= '0;
      pcPlus2R  <= '0;
      suppressR <= 1'b0;
      flushR    <= 1'b0;
    end else if (strobe.load) begin
      opR       <= xferOp_t'(cmdOp);
      maskR     <= cmdList;
      pcPlus2R  <= cmdPc + DATA_W'(2);
      flushR    <= 1'b0;
      if (cmdOp[1]) begin
        extraR    <= (cmdList == '0);
        ptrR      <= cmdBase & ALIGN_MASK;
        suppressR <= cmdOp[0] && cmdList[cmdBaseIdx];
      end else begin
        extraR    <= cmdExtra;
        ptrR      <= cmdBase;
        suppressR <= 1'b0;
      end
    end else if (strobe.step) begin
      if (curIsExtra) extraR <= 1'b0;
      else            maskR  <= maskR & ~curOh;
      ptrR <= ptrNext;
      if (isLoad && (curIdx == IDX_PC)) flushR <= 1'b1;
    end
  end
endmodule

// File: rtl/reglist_xfer_seq.sv
module reglist_xfer_seq
  import rlx_pkg::*;
#(
  parameter int LIST_W       = 8,
  parameter int DATA_W       = 32,
  parameter int EMPTY_STRIDE = 64,
  localparam int SEL_W       = $clog2(LIST_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [LIST_W-1:0] cmdList,
  input  logic              cmdExtra,
  input  logic [SEL_W-1:0]  cmdBaseIdx,
  input  logic [DATA_W-1:0] cmdBase,
  input  logic [DATA_W-1:0] cmdPc,
  output logic              busy,
  output logic              memReq,
  output logic              memWe,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memRdata,
  output logic              rfRdEn,
  output logic [IDX_W-1:0]  rfRdIdx,
  input  logic [DATA_W-1:0] rfRdData,
  output logic              rfWrEn,
  output logic [IDX_W-1:0]  rfWrIdx,
  output logic [DATA_W-1:0] rfWrData,
  output logic              done,
  output logic              wbEn,
  output logic [DATA_W-1:0] wbData,
  output logic              flush
);
  seqStrobe_t strobe;
  logic itemsLeft, lastItem, wbKeep, flushPend;

  rlx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .memReady(memReady),
    .itemsLeft(itemsLeft), .lastItem(lastItem), .strobe(strobe),
    .memReq(memReq), .busy(busy), .done(done)
  );

  rlx_datapath #(.LIST_W(LIST_W), .DATA_W(DATA_W), .EMPTY_STRIDE(EMPTY_STRIDE)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .memReq(memReq),
    .cmdOp(cmdOp), .cmdList(cmdList), .cmdExtra(cmdExtra), .cmdBaseIdx(cmdBaseIdx),
    .cmdBase(cmdBase), .cmdPc(cmdPc), .memRdata(memRdata), .rfRdData(rfRdData),
    .itemsLeft(itemsLeft), .lastItem(lastItem), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .rfRdEn(rfRdEn), .rfRdIdx(rfRdIdx), .rfWrEn(rfWrEn),
    .rfWrIdx(rfWrIdx), .rfWrData(rfWrData), .wbData(wbData), .wbKeep(wbKeep),
    .flushPend(flushPend)
  );

  assign wbEn  = done && wbKeep;
  assign flush = done && flushPend;
endmodule

// File: rtl/reglist_xfer_seq_chk.sv
module reglist_xfer_seq_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              busy,
  input logic              memReq,
  input logic              memWe,
  input logic [DATA_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata,
  input logic              memReady,
  input logic              rfWrEn,
  input logic [3:0]        rfWrIdx,
  input logic [DATA_W-1:0] rfWrData,
  input logic              done,
  input logic              wbEn,
  input logic              flush
);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata));
  // R3
  pc_bit0_chk: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn && (rfWrIdx == 4'd15) |-> !rfWrData[0]);
  // R2
  wr_on_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> memReq && memReady && !memWe);
  // R6
  wb_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> done);
  // R3
  flush_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> done);
  // R8
  done_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy && !done);
  // R8
  start_on_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmdValid));
  // R10
  req_needs_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy && !done);
endmodule

bind reglist_xfer_seq reglist_xfer_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .busy(busy), .memReq(memReq),
  .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memReady(memReady),
  .rfWrEn(rfWrEn), .rfWrIdx(rfWrIdx), .rfWrData(rfWrData), .done(done),
  .wbEn(wbEn), .flush(flush)
);

// File: tb/reglist_xfer_seq_bench.sv
module reglist_xfer_seq_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = '0;
  logic [7:0]  cmdList = '0;
  logic        cmdExtra = 1'b0;
  logic [2:0]  cmdBaseIdx = '0;
  logic [31:0] cmdBase = '0;
  logic [31:0] cmdPc = '0;
  logic        busy, memReq, memWe, rfRdEn, rfWrEn, done, wbEn, flush;
  logic [31:0] memAddr, memWdata, memRdata, rfRdData, rfWrData, wbData;
  logic        memReady = 1'b0;
  logic [3:0]  rfRdIdx, rfWrIdx;

  logic [31:0] memModel [64];
  logic [31:0] rfModel  [16];

  int total = 0;
  int failed = 0;

  // expected command results
  int          expN;
  logic [31:0] expAddr [16];
  logic        expWe   [16];
  logic [31:0] expData [16];
  logic [3:0]  expIdx  [16];
  logic [31:0] expWb;
  logic        expWbEn, expFlush;

  always #5 clk = ~clk;

  assign memRdata = memModel[memAddr[7:2]];
  assign rfRdData = rfModel[rfRdIdx];

  reglist_xfer_seq u_reglist_xfer_seq (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdList(cmdList),
    .cmdExtra(cmdExtra), .cmdBaseIdx(cmdBaseIdx), .cmdBase(cmdBase), .cmdPc(cmdPc),
    .busy(busy), .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memReady(memReady), .memRdata(memRdata), .rfRdEn(rfRdEn), .rfRdIdx(rfRdIdx),
    .rfRdData(rfRdData), .rfWrEn(rfWrEn), .rfWrIdx(rfWrIdx), .rfWrData(rfWrData),
    .done(done), .wbEn(wbEn), .wbData(wbData), .flush(flush)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic addExp(input logic [31:0] a, input logic we, input logic [3:0] idx, input logic [31:0] d);
    expAddr[expN] = a;
    expWe[expN]   = we;
    expIdx[expN]  = idx;
    expData[expN] = d;
    expN++;
  endtask

  function automatic logic [31:0] rdMem(input logic [31:0] a, input logic [3:0] idx);
    logic [31:0] v = memModel[a[7:2]];
    if (idx == 4'd15) v[0] = 1'b0;
    return v;
  endfunction

  // builds the expected access list and completion from the requirements
  task automatic computeExp(input logic [1:0] op, input logic [7:0] list, input logic extra,
                            input logic [2:0] bIdx, input logic [31:0] base, input logic [31:0] pc);
    logic [31:0] p;
    logic [31:0] a;
    expN = 0; expFlush = 1'b0; expWbEn = 1'b1;
    case (op)
      2'd0: begin  // R1 push
        p = base;
        if (extra) begin p = p - 4; addExp(p & ~32'h3, 1'b1, 4'd14, rfModel[14]); end
        for (int r = 7; r >= 0; r--)
          if (list[r]) begin p = p - 4; addExp(p & ~32'h3, 1'b1, 4'(r), rfModel[r]); end
      end
      2'd1: begin  // R2 pop
        p = base;
        for (int r = 0; r < 8; r++)
          if (list[r]) begin a = p & ~32'h3; addExp(a, 1'b0, 4'(r), rdMem(a, 4'(r))); p = a + 4; end
        if (extra) begin a = p & ~32'h3; addExp(a, 1'b0, 4'd15, rdMem(a, 4'd15)); p = a + 4; expFlush = 1'b1; end
      end
      default: begin  // R4 / R7 multiple transfer
        p = base & ~32'h3;
        if (list == 8'h00) begin
          if (op == 2'd2) addExp(p, 1'b1, 4'd15, pc + 2);
          else begin addExp(p, 1'b0, 4'd15, rdMem(p, 4'd15)); expFlush = 1'b1; end
          p = p + 32'h40;
        end else begin
          for (int r = 0; r < 8; r++)
            if (list[r]) begin
              addExp(p, op == 2'd2, 4'(r), (op == 2'd2) ? rfModel[r] : rdMem(p, 4'(r)));
              p = p + 4;
            end
          expWbEn = !((op == 2'd3) && list[bIdx]);
        end
      end
    endcase
    expWb = p;
  endtask

  task automatic runCmd(input logic [1:0] op, input logic [7:0] list, input logic extra,
                        input logic [2:0] bIdx, input logic [31:0] base, input logic [31:0] pc,
                        input bit intrude);
    string tag;
    int seen = 0;
    int cyc = 0;
    int lastStep = -10;
    bit stalled = 1'b0;
    bit sawStall = 1'b0;
    int stallBad = 0;
    logic [31:0] stA, stD;
    logic stW;
    computeExp(op, list, extra, bIdx, base, pc);
    if (op == 2'd0) tag = "R1";
    else if (op == 2'd1) tag = "R2";
    else if (list == 8'h00) tag = "R7";
    else tag = "R4";
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdList = list; cmdExtra = extra;
    cmdBaseIdx = bIdx; cmdBase = base; cmdPc = pc; memReady = 1'b0;
    @(negedge clk);
    forever begin
      cmdValid = 1'b0;
      memReady = ($urandom % 4) != 0;
      #2;
      if (stalled) begin
        sawStall = 1'b1;
        if (!(memReq && memAddr == stA && memWe == stW && (!stW || memWdata == stD))) stallBad++;
      end
      stalled = memReq && !memReady;
      stA = memAddr; stW = memWe; stD = memWdata;
      if (memReq && memReady) begin
        if (seen < expN) begin
          chk(memAddr == expAddr[seen] && memWe == expWe[seen], tag, memAddr, expAddr[seen]);
          if (expWe[seen])
            chk(memWdata == expData[seen], tag, memWdata, expData[seen]);
          else
            chk(rfWrEn && rfWrIdx == expIdx[seen] && rfWrData == expData[seen],
                (expIdx[seen] == 4'd15) ? "R3" : tag, rfWrData, expData[seen]);
          if (expWe[seen]) memModel[memAddr[7:2]] = memWdata;
        end
        seen++;
        lastStep = cyc;
      end
      if (done) break;
      if (intrude && cyc == 2) begin
        // offered while busy: must be ignored (R8)
        cmdValid = 1'b1; cmdOp = ~op; cmdList = ~list; cmdBase = base + 32'h80;
      end
      cyc++;
      if (cyc > 300) begin
        chk(1'b0, "R8 timeout", 32'(cyc), 32'd0);
        return;
      end
      @(negedge clk);
    end
    chk(seen == expN, "R8 access count", 32'(seen), 32'(expN));
    if (expN > 0) chk(cyc == lastStep + 1, "R8 done timing", 32'(cyc - lastStep), 32'd1);
    chk(wbData == expWb, (tag == "R7") ? "R7" : "R5", wbData, expWb);
    chk(wbEn == expWbEn, "R6", 32'(wbEn), 32'(expWbEn));
    chk(flush == expFlush, "R3", 32'(flush), 32'(expFlush));
    if (sawStall) chk(stallBad == 0, "R9", 32'(stallBad), 32'd0);
    @(negedge clk);
    memReady = 1'b0;
    #2;
    chk(!busy && !done, "R8 idle after done", {30'd0, busy, done}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    total++; failed++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 64; i++) memModel[i] = $urandom;
    for (int i = 0; i < 16; i++) rfModel[i] = $urandom;
    repeat (3) @(negedge clk);
    #2;
    // R10 reset state
    chk(!busy && !memReq && !done, "R10", {29'd0, busy, memReq, done}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    #2;
    chk(!busy && !memReq && !done, "R10", {29'd0, busy, memReq, done}, 32'd0);

    // directed corner cases
    runCmd(2'd0, 8'b1010_0101, 1'b1, 3'd0, 32'h0000_0180, 32'h0, 1'b1); // R1 push with link
    runCmd(2'd0, 8'b0000_0011, 1'b0, 3'd0, 32'h0000_0142, 32'h0, 1'b0); // R1 unaligned SP
    runCmd(2'd1, 8'b1100_0001, 1'b1, 3'd0, 32'h0000_0100, 32'h0, 1'b1); // R2 R3 pop with PC
    runCmd(2'd1, 8'b0001_1000, 1'b0, 3'd0, 32'h0000_0123, 32'h0, 1'b0); // R2 unaligned SP
    runCmd(2'd0, 8'h00,        1'b0, 3'd0, 32'h0000_0150, 32'h0, 1'b0); // R5 empty push
    runCmd(2'd1, 8'h00,        1'b0, 3'd0, 32'h0000_0150, 32'h0, 1'b0); // R5 empty pop
    runCmd(2'd2, 8'b0110_1001, 1'b0, 3'd3, 32'h0000_0107, 32'h0, 1'b1); // R4 R6 stm base listed
    runCmd(2'd3, 8'b0010_0110, 1'b0, 3'd2, 32'h0000_0110, 32'h0, 1'b0); // R6 ldm base listed
    runCmd(2'd3, 8'b0010_0110, 1'b0, 3'd0, 32'h0000_0111, 32'h0, 1'b0); // R4 ldm writeback
    runCmd(2'd3, 8'h00,        1'b0, 3'd1, 32'h0000_0133, 32'h0, 1'b0); // R7 empty ldm
    runCmd(2'd2, 8'h00,        1'b0, 3'd1, 32'h0000_0160, 32'h0000_2468, 1'b1); // R7 empty stm
    runCmd(2'd3, 8'hFF,        1'b0, 3'd7, 32'h0000_0100, 32'h0, 1'b0); // R4 full list

    // constrained random commands
    for (int n = 0; n < 60; n++) begin
      logic [7:0] lst;
      logic [31:0] b;
      lst = (($urandom % 8) == 0) ? 8'h00 : 8'($urandom);
      b = 32'h100 + 32'(($urandom % 48) * 4) + ((($urandom % 4) == 0) ? 32'($urandom % 4) : 32'd0);
      runCmd(2'($urandom), lst, 1'($urandom), 3'($urandom), b, $urandom, ($urandom % 3) == 0);
    end

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule